// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block sits between a processor core's memory-access port and a shared external parallel bus. An outside master asks for the bus by pulling an active-low hold request low. The block answers with an active-low hold acknowledge. The request is asynchronous, so it first passes through a flop synchronizer. If the core has a bus cycle running, the block lets that cycle finish. It then takes data off the bus first, and after that strobe, read/write and address. The outside master then owns the wires.

While the bus is granted away, the core keeps running. It is stalled only when it actually asks for the bus. The first write it issues in that time is captured in a one-entry posted-write slot and the core moves on. A read, or a second write while the slot is full, stalls the core. When the request is withdrawn, the drivers come back, the acknowledge is withdrawn, and the posted write goes out before any stalled access. A control bit, driven from a register outside the block, refuses hold. It forces the block back out of any active hold and makes it ignore later requests.

Each bus access holds strobe low for a fixed, parameterized number of clocks. Read data is registered and returned to the core together with a one-cycle valid pulse.

Top module: `bus_hold_arb`

## Requirements
- R1: After synchronous reset, hold acknowledge is high, the control and data output enables are 1, strobe is high, and no stall is raised while there is no core request.
- R2: With the bus idle and the refuse bit clear, hold acknowledge goes low on the 4th rising clock edge after the request is first seen low: 2 synchronizer flops, one release cycle and then the grant.
- R3: Hold acknowledge is never low while strobe is low. If hold is asked for during an access, the access completes first and its read data is still returned.
- R4: In the hold sequence, the data enable drops one cycle before the grant. The control enable (strobe, read/write, address) drops in the same cycle that acknowledge goes low, and strobe stays high throughout.
- R5: While the bus is not owned, a core write that finds the posted slot empty is accepted without a stall.
- R6: While the bus is not owned, a core read is always stalled, and a core write is stalled while the posted slot is full.
- R7: Once the request returns high, acknowledge goes high and the control enable returns to 1 on the 3rd rising edge. The data enable returns to 1 one edge later.
- R8: After hold ends, the first bus access is the posted write (read/write = 0, meaning write, with the posted address and data). It goes out ahead of a core access that was stalled.
- R9: While the refuse bit is 1, acknowledge is high from the next edge onward and a hold request is ignored. Setting the bit during a granted hold ends that hold.
- R10: Every bus access holds strobe low for exactly ACC_CYC cycles. bus_rd is 1 for a read. On a read, core_rvalid pulses once with core_rdata equal to the bus_rdata sampled on the last strobe cycle. No new access starts while one is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_n | input | 1 | Asynchronous active-low bus request from the outside master |
| holda_n | output | 1 | Active-low hold acknowledge |
| refuse_hold | input | 1 | Control bit: 1 refuses and ends hold |
| core_req | input | 1 | Core asks for a bus access |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | AW | Core access address |
| core_wdata | input | DW | Core write data |
| core_stall | output | 1 | Request not taken this cycle |
| core_rvalid | output | 1 | Read data valid pulse |
| core_rdata | output | DW | Registered read data |
| bus_strb_n | output | 1 | Active-low bus strobe |
| bus_rd | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |
| ctrl_oe | output | 1 | Output enable for strobe, read/write and address |
| data_oe | output | 1 | Output enable for write data |

## Verification
The bench builds the block with AW=8, DW=16, ACC_CYC=3 and SYNC_STAGES=2. With a 3-cycle strobe, a hold request can land in the middle of an access, so the wait-for-cycle-end path is reached. The two-flop synchronizer makes the grant and release latencies exact edge counts that the bench can measure. The narrow address and data keep the vector table small, while reads and writes still carry distinct values.

// File: rtl/hold_pkg.sv
package hold_pkg;
  typedef enum logic [2:0] {
    BUS_OWNED      = 3'd0,
    WAIT_CYCLE_END = 3'd1,
    RELEASE        = 3'd2,
    HELD           = 3'd3,
    RECLAIM        = 3'd4
  } hold_state_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_n_async,
  output logic hold_req
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[STAGES-2:0], ~hold_n_async};
  end

  assign hold_req = sync_q[STAGES-1];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        hold_req,
  input  logic        refuse,
  input  logic        bus_busy,
  output hold_state_e state,
  output logic        hold_want,
  output logic        holda_n,
  output logic        ctrl_oe,
  output logic        data_oe
);
  hold_state_e state_d;

  assign hold_want = hold_req & ~refuse;

  always_comb begin
    state_d = state;
    case (state)
      BUS_OWNED:      if (hold_want) state_d = bus_busy ? WAIT_CYCLE_END : RELEASE;
      WAIT_CYCLE_END: if (!hold_want) state_d = BUS_OWNED;
                      else if (!bus_busy) state_d = RELEASE;
      RELEASE:        state_d = hold_want ? HELD : RECLAIM;
      HELD:           if (!hold_want) state_d = RECLAIM;
      RECLAIM:        state_d = BUS_OWNED;
      default:        state_d = BUS_OWNED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= BUS_OWNED;
      holda_n <= 1'b1;
      ctrl_oe <= 1'b1;
      data_oe <= 1'b1;
    end else begin
      state   <= state_d;
      holda_n <= (state_d != HELD);
      ctrl_oe <= (state_d != HELD);
      data_oe <= (state_d == BUS_OWNED) || (state_d == WAIT_CYCLE_END);
    end
  end

  // R9: with refuse set, no grant can appear on the following edge
  assert_refuse_R9: assert property (@(posedge clk) disable iff (rst)
    refuse |=> holda_n);
  // R2: a grant is only entered from the release step
  assert_grant_path_R2: assert property (@(posedge clk) disable iff (rst)
    (state == HELD && $past(state) != HELD) |-> $past(state) == RELEASE);
endmodule

// File: rtl/post_buf.sv
module post_buf #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          issue,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= in_addr;
      data  <= in_data;
    end else if (issue) begin
      valid <= 1'b0;
    end
  end

  // R6: a full slot is never overwritten
  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (rst)
    load |-> !valid);
  // R8: only issuing empties the slot, and its contents hold meanwhile
  assert_slot_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (valid && !issue) |=> (valid && $stable(addr) && $stable(data)));
endmodule

// File: rtl/bus_engine.sv
module bus_engine #(
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int ACC_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_data,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          strb_n,
  output logic          rd,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);
  localparam int CW = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACC_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      strb_n <= 1'b1;
      rd     <= 1'b1;
      addr   <= '0;
      wdata  <= '0;
      cnt    <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= 1'b0;
      if (launch) begin
        busy   <= 1'b1;
        strb_n <= 1'b0;
        rd     <= ~l_we;
        addr   <= l_addr;
        wdata  <= l_data;
        cnt    <= '0;
      end else if (busy) begin
        if (cnt == LAST) begin
          busy   <= 1'b0;
          strb_n <= 1'b1;
          if (rd) begin
            rvalid <= 1'b1;
            rdata  <= bus_rdata;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R10: no access is started on top of a running one
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    launch |-> !busy);
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
  import hold_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int ACC_CYC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_n,
  output logic          holda_n,
  input  logic          refuse_hold,
  input  logic          core_req,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          core_stall,
  output logic          core_rvalid,
  output logic [DW-1:0] core_rdata,
  output logic          bus_strb_n,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          ctrl_oe,
  output logic          data_oe
);
  hold_state_e   state;
  logic          hold_req, hold_want, busy;
  logic          pw_valid;
  logic [AW-1:0] pw_addr;
  logic [DW-1:0] pw_data;
  logic          own_idle, launch_pw, launch_core, post_core, launch;

  hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .hold_n_async(hold_n), .hold_req(hold_req));

  hold_fsm u_fsm (
    .clk(clk), .rst(rst), .hold_req(hold_req), .refuse(refuse_hold),
    .bus_busy(busy), .state(state), .hold_want(hold_want),
    .holda_n(holda_n), .ctrl_oe(ctrl_oe), .data_oe(data_oe));

  assign own_idle    = (state == BUS_OWNED) && !hold_want && !busy;
  assign launch_pw   = own_idle && pw_valid;
  assign launch_core = own_idle && !pw_valid && core_req;
  assign post_core   = (state != BUS_OWNED) && core_req && core_we && !pw_valid;
  assign launch      = launch_pw || launch_core;
  assign core_stall  = core_req && !(launch_core || post_core);

  post_buf #(.AW(AW), .DW(DW)) u_post (
    .clk(clk), .rst(rst), .load(post_core), .issue(launch_pw),
    .in_addr(core_addr), .in_data(core_wdata),
    .valid(pw_valid), .addr(pw_addr), .data(pw_data));

  bus_engine #(.AW(AW), .DW(DW), .ACC_CYC(ACC_CYC)) u_eng (
    .clk(clk), .rst(rst), .launch(launch),
    .l_we(launch_pw ? 1'b1 : core_we),
    .l_addr(launch_pw ? pw_addr : core_addr),
    .l_data(launch_pw ? pw_data : core_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .strb_n(bus_strb_n), .rd(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rvalid(core_rvalid), .rdata(core_rdata));

  // R3: grant and an active strobe never coexist
  assert_holda_no_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !holda_n |-> bus_strb_n);
  // R4: while granted, every driver is released
  assert_drivers_off_R4: assert property (@(posedge clk) disable iff (rst)
    !holda_n |-> (!ctrl_oe && !data_oe));
  // R4: data is already off on the cycle before the grant appears
  assert_data_first_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(holda_n) |-> $past(!data_oe));
  // R6: reads never pass while the bus is away
  assert_read_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (core_req && !core_we && state != BUS_OWNED) |-> core_stall);
endmodule

// File: tb/sim_bus_hold_arb.sv
`timescale 1ns/1ps
module sim_bus_hold_arb;
  localparam int AW = 8, DW = 16, ACC = 3;

  logic clk = 0, rst = 1;
  logic hold_n = 1, refuse_hold = 0;
  logic core_req = 0, core_we = 0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0, bus_rdata = '0;
  logic holda_n, core_stall, core_rvalid, bus_strb_n, bus_rd, ctrl_oe, data_oe;
  logic [DW-1:0] core_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_hold_arb #(.AW(AW), .DW(DW), .ACC_CYC(ACC), .SYNC_STAGES(2)) u0 (.*);

  // {we, addr, wdata, rdata}
  localparam logic [40:0] VEC [4] = '{
    {1'b1, 8'h10, 16'hA5A5, 16'h0000},
    {1'b0, 8'h22, 16'h0000, 16'hBEEF},
    {1'b1, 8'hFF, 16'h0F0F, 16'h0000},
    {1'b0, 8'h01, 16'h0000, 16'h1357}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // run one access in the owned state; returns strobe-low length and read data
  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int low, output int nvalid, output logic [DW-1:0] rd_got);
    core_req = 1; core_we = we; core_addr = a; core_wdata = d;
    #1;
    while (core_stall) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    core_req = 0;
    low = 0; nvalid = 0; rd_got = '0;
    for (int i = 0; i < 12; i++) begin
      if (!bus_strb_n) begin
        low++;
        if (low == 1) begin
          chk(bus_addr == a, "R10 addr", bus_addr, a);
          chk(bus_rd == !we, "R10 rd", bus_rd, !we);
          if (we) chk(bus_wdata == d, "R10 wdata", bus_wdata, d);
        end
      end
      if (core_rvalid) begin nvalid++; rd_got = core_rdata; end
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    chk(0, "watchdog", 0, 1);
    if (!finished) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int low, nv, n;
    logic [DW-1:0] got;
    bit overlap, saw_grant;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(holda_n && ctrl_oe && data_oe && bus_strb_n && !core_stall, "R1 reset",
        {holda_n, ctrl_oe, data_oe, bus_strb_n, core_stall}, 5'b11110);

    // R10 vector table of owned-bus accesses
    foreach (VEC[k]) begin
      bus_rdata = VEC[k][15:0];
      access(VEC[k][40], VEC[k][39:32], VEC[k][31:16], low, nv, got);
      chk(low == ACC, "R10 strobe length", low, ACC);
      if (!VEC[k][40]) begin
        chk(nv == 1, "R10 rvalid count", nv, 1);
        chk(got == VEC[k][15:0], "R10 read data", got, VEC[k][15:0]);
      end else chk(nv == 0, "R10 no rvalid on write", nv, 0);
    end

    // R2/R4 hold entry from idle
    hold_n = 0;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 3) chk(!data_oe && ctrl_oe && holda_n && bus_strb_n, "R4 data off first",
                      {data_oe, ctrl_oe, holda_n}, 3'b011);
      if (!holda_n) break;
    end
    chk(n == 4, "R2 grant latency", n, 4);
    chk(!ctrl_oe && !data_oe && bus_strb_n, "R4 drivers off at grant", {ctrl_oe, data_oe}, 0);

    // R5 first write posted, R6 second write and read stall
    core_req = 1; core_we = 1; core_addr = 8'h5A; core_wdata = 16'h1234;
    #1 chk(!core_stall, "R5 posted write accepted", core_stall, 0);
    @(negedge clk);
    core_addr = 8'h66; core_wdata = 16'h9999;
    #1 chk(core_stall, "R6 second write stalls", core_stall, 1);
    @(negedge clk);
    #1 chk(core_stall, "R6 second write still stalled", core_stall, 1);
    core_we = 0; core_addr = 8'h33;
    #1 chk(core_stall, "R6 read stalls in hold", core_stall, 1);
    chk(!holda_n && bus_strb_n, "R5 hold kept, no strobe", {holda_n, bus_strb_n}, 2'b01);

    // R7 release latency, R8 posted write goes first, read still pending
    bus_rdata = 16'hC0DE;
    @(negedge clk);
    hold_n = 1;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (holda_n) break;
    end
    chk(n == 3, "R7 release latency", n, 3);
    chk(ctrl_oe && !data_oe, "R7 ctrl back before data", {ctrl_oe, data_oe}, 2'b10);
    @(negedge clk);
    chk(data_oe, "R7 data enable back", data_oe, 1);
    n = 0;
    while (bus_strb_n && n < 10) begin @(negedge clk); n++; end
    chk(bus_addr == 8'h5A && !bus_rd && bus_wdata == 16'h1234, "R8 posted write first",
        {bus_rd, bus_addr, bus_wdata}, {1'b0, 8'h5A, 16'h1234});
    chk(core_stall, "R8 read waits behind posted write", core_stall, 1);
    #1;
    while (core_stall) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    core_req = 0;
    chk(!bus_strb_n && bus_rd && bus_addr == 8'h33, "R8 stalled read follows",
        {bus_strb_n, bus_rd, bus_addr}, {1'b0, 1'b1, 8'h33});
    repeat (6) @(negedge clk);

    // R3 hold arriving during a read
    bus_rdata = 16'h7E57;
    core_req = 1; core_we = 0; core_addr = 8'h44;
    @(posedge clk); @(negedge clk);
    core_req = 0;
    hold_n = 0;
    overlap = 0; saw_grant = 0; nv = 0; got = '0;
    for (int i = 0; i < 12; i++) begin
      if (!holda_n && !bus_strb_n) overlap = 1;
      if (!holda_n) saw_grant = 1;
      if (core_rvalid) begin nv++; got = core_rdata; end
      @(negedge clk);
    end
    chk(!overlap, "R3 no grant during strobe", overlap, 0);
    chk(saw_grant, "R3 grant after cycle end", saw_grant, 1);
    chk(nv == 1 && got == 16'h7E57, "R3 read completed", got, 16'h7E57);
    hold_n = 1;
    repeat (6) @(negedge clk);

    // R9 refuse bit
    refuse_hold = 1; hold_n = 0;
    saw_grant = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (!holda_n) saw_grant = 1; end
    chk(!saw_grant, "R9 request ignored", saw_grant, 0);
    refuse_hold = 0;
    repeat (2) @(negedge clk);
    chk(!holda_n, "R9 grant once refuse clears", holda_n, 0);
    refuse_hold = 1;
    @(negedge clk);
    chk(holda_n && ctrl_oe, "R9 refuse ends hold", {holda_n, ctrl_oe}, 2'b11);
    saw_grant = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (!holda_n) saw_grant = 1; end
    chk(!saw_grant, "R9 later request still ignored", saw_grant, 0);
    hold_n = 1; refuse_hold = 0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule